// File: doc/BRIEF.md
# Dual Timer/Counter with Mode Control

This block holds two 16-bit timer/counters, each split into a low byte and a high byte. Both advance on a shared count-enable tick, and each has a 2-bit mode field that picks how the bytes chain. The four modes are:

- a 13-bit prescaled count;
- a full 16-bit count;
- an 8-bit count that reloads from the high byte;
- a special mode. For timer 0 the special mode splits it into two free 8-bit counters. For timer 1 it freezes the count.

An 8-bit control register holds the run bits and the overflow flags. Each overflow flag also drives an interrupt request, which the interrupt controller can acknowledge. Software loads the count bytes, the mode register and the control register through write strobes that share one data bus.

Top module: `twin_timer`

## Requirements
- R1: After reset, all four count bytes, the control register and the mode register are zero, and both interrupt requests are low.
- R2: In mode 2, a tick that finds the low byte at FFh sets the overflow flag. It loads the low byte with the value the high byte held before that edge, and the high byte is unchanged.
- R3: In mode 1, the pair {high, low} counts as one 16-bit value. A tick at FFFFh gives 0000h and sets the overflow flag.
- R4: In mode 0, only low-byte bits 4:0 count and bits 7:5 keep their value. When bits 4:0 wrap from 1Fh, the high byte increments. The overflow flag is set only when the high byte is FFh at that wrap.
- R5: The overflow sets its flag on the same clock edge that wraps the count. The flag is bit 5 of the control register for timer 0 and bit 7 for timer 1. irq0 follows bit 5 and irq1 follows bit 7.
- R6: A control write clears a flag when it writes 0 to that bit. The acknowledge input (ack0 or ack1) also clears its timer's flag. A hardware overflow in the same cycle wins over either, and the flag ends up 1.
- R7: A timer counts only on a cycle where tick is 1 and its run bit is 1. The run bit is control bit 4 for timer 0 and bit 6 for timer 1.
- R8: With timer 1 in mode 3, the timer 1 count bytes hold their value under ticks.
- R9: Timer 0 in mode 3 splits into two 8-bit counters. Its low byte counts under bit 4 and sets bit 5. Its high byte counts under bit 6 and sets bit 7. While this holds, overflows of timer 1 do not set bit 7.
- R10: A write to a count byte takes effect in place of a count on the same edge.
- R11: The control register reads back whatever was written in bits 3:0, which are plain storage. The mode register write takes wr_data[1:0] as the timer 0 mode and wr_data[3:2] as the timer 1 mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable |
| wr_ctl | input | 1 | Write the control register |
| wr_mode | input | 1 | Write the mode register |
| wr_lo0 | input | 1 | Write timer 0 low byte |
| wr_hi0 | input | 1 | Write timer 0 high byte |
| wr_lo1 | input | 1 | Write timer 1 low byte |
| wr_hi1 | input | 1 | Write timer 1 high byte |
| wr_data | input | 8 | Shared write data |
| ack0 | input | 1 | Interrupt acknowledge, timer 0 |
| ack1 | input | 1 | Interrupt acknowledge, timer 1 |
| lo0 | output | 8 | Timer 0 low byte |
| hi0 | output | 8 | Timer 0 high byte |
| lo1 | output | 8 | Timer 1 low byte |
| hi1 | output | 8 | Timer 1 high byte |
| ctl_q | output | 8 | Control register |
| irq0 | output | 1 | Timer 0 interrupt request |
| irq1 | output | 1 | Timer 1 interrupt request |

## Verification
Every result is one register away from its stimulus. A count, a reload, a flag set, a flag clear and a write all show after the first rising edge that sees the stimulus. The irq outputs follow the flags with no extra delay. Each stimulus is applied at a falling edge and held across exactly the number of rising edges that the expected value assumes. The result is then sampled at the next falling edge, so every check reads the value one edge after the stimulus.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W = 8;
  localparam int M0_LO_BITS = 5;
  localparam logic [BYTE_W-1:0] B_ONE = 1;
  localparam logic [M0_LO_BITS-1:0] P_ONE = 1;
  localparam logic [2*BYTE_W-1:0] W_ONE = 1;

  typedef enum logic [1:0] {MD_13 = 2'd0, MD_16 = 2'd1, MD_RLD = 2'd2, MD_SPLIT = 2'd3} tmode_e;

  typedef struct packed {
    logic [BYTE_W-1:0] hi;
    logic [BYTE_W-1:0] lo;
    logic              ovf;
  } step_t;

  function automatic logic [BYTE_W-1:0] bump(input logic [BYTE_W-1:0] v);
    return v + B_ONE;
  endfunction

  // one count step for the chained modes (0, 1, 2)
  function automatic step_t count_step(input tmode_e md, input logic [BYTE_W-1:0] hi,
                                       input logic [BYTE_W-1:0] lo);
    step_t r;
    r.hi = hi;
    r.lo = lo;
    r.ovf = 1'b0;
    case (md)
      MD_13: begin
        if (&lo[M0_LO_BITS-1:0]) begin
          r.lo[M0_LO_BITS-1:0] = '0;
          r.hi = bump(hi);
          r.ovf = &hi;
        end else begin
          r.lo[M0_LO_BITS-1:0] = lo[M0_LO_BITS-1:0] + P_ONE;
        end
      end
      MD_16: begin
        {r.hi, r.lo} = {hi, lo} + W_ONE;
        r.ovf = &{hi, lo};
      end
      MD_RLD: begin
        if (&lo) begin
          r.lo = hi;
          r.ovf = 1'b1;
        end else begin
          r.lo = bump(lo);
        end
      end
      default: ;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter bit SPLIT_M3 = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [1:0]        mode,
  input  logic              run_a,
  input  logic              run_b,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] lo_q,
  output logic [BYTE_W-1:0] hi_q,
  output logic              ovf_a,
  output logic              ovf_b
);
  tmode_e md;
  step_t  st;
  logic [BYTE_W-1:0] lo_n, hi_n, sp_lo, sp_hi;
  logic sp_oa, sp_ob;

  assign md = tmode_e'(mode);
  assign st = count_step(md, hi_q, lo_q);

  // mode 3 variant: split counters or frozen count
  if (SPLIT_M3) begin : g_split
    always_comb begin
      sp_lo = lo_q;
      sp_hi = hi_q;
      sp_oa = 1'b0;
      sp_ob = 1'b0;
      if (tick && run_a) begin
        sp_lo = bump(lo_q);
        sp_oa = &lo_q;
      end
      if (tick && run_b) begin
        sp_hi = bump(hi_q);
        sp_ob = &hi_q;
      end
    end
  end else begin : g_hold
    assign sp_lo = lo_q;
    assign sp_hi = hi_q;
    assign sp_oa = 1'b0;
    assign sp_ob = 1'b0;
  end

  always_comb begin
    lo_n  = lo_q;
    hi_n  = hi_q;
    ovf_a = 1'b0;
    ovf_b = 1'b0;
    if (md == MD_SPLIT) begin
      lo_n  = sp_lo;
      hi_n  = sp_hi;
      ovf_a = sp_oa;
      ovf_b = sp_ob;
    end else if (tick && run_a) begin
      lo_n  = st.lo;
      hi_n  = st.hi;
      ovf_a = st.ovf;
    end
    if (wr_lo) lo_n = wr_data;
    if (wr_hi) hi_n = wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_n;
      hi_q <= hi_n;
    end
  end
endmodule

// File: rtl/tmr_ctl.sv
module tmr_ctl
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctl,
  input  logic              wr_mode,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              set_f0,
  input  logic              set_f1,
  input  logic              ack0,
  input  logic              ack1,
  output logic [BYTE_W-1:0] ctl_q,
  output logic [3:0]        mode_q
);
  localparam int F1_B = 7;
  localparam int F0_B = 5;
  logic [BYTE_W-1:0] ctl_n;

  always_comb begin
    ctl_n = ctl_q;
    if (wr_ctl) begin
      ctl_n = wr_data;
    end else begin
      if (ack0) ctl_n[F0_B] = 1'b0;
      if (ack1) ctl_n[F1_B] = 1'b0;
    end
    if (set_f0) ctl_n[F0_B] = 1'b1;
    if (set_f1) ctl_n[F1_B] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      mode_q <= '0;
    end else begin
      ctl_q <= ctl_n;
      if (wr_mode) mode_q <= wr_data[3:0];
    end
  end
endmodule

// File: rtl/twin_timer.sv
module twin_timer
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_ctl,
  input  logic              wr_mode,
  input  logic              wr_lo0,
  input  logic              wr_hi0,
  input  logic              wr_lo1,
  input  logic              wr_hi1,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              ack0,
  input  logic              ack1,
  output logic [BYTE_W-1:0] lo0,
  output logic [BYTE_W-1:0] hi0,
  output logic [BYTE_W-1:0] lo1,
  output logic [BYTE_W-1:0] hi1,
  output logic [BYTE_W-1:0] ctl_q,
  output logic              irq0,
  output logic              irq1
);
  localparam int NT = 2;
  localparam int RUN0_B = 4;
  localparam int RUN1_B = 6;

  logic [3:0]        mode_q;
  logic [1:0]        t0_mode, t1_mode;
  logic              run0, run1, t0_split;
  logic              set_tf0, set_tf1;
  logic [NT-1:0]     wl, wh, ra, rb, oa, ob;
  logic [BYTE_W-1:0] lo_v [NT];
  logic [BYTE_W-1:0] hi_v [NT];
  logic [1:0]        md_v [NT];

  assign t0_mode  = mode_q[1:0];
  assign t1_mode  = mode_q[3:2];
  assign run0     = ctl_q[RUN0_B];
  assign run1     = ctl_q[RUN1_B];
  assign t0_split = (t0_mode == MD_SPLIT);

  assign wl   = {wr_lo1, wr_lo0};
  assign wh   = {wr_hi1, wr_hi0};
  assign ra   = {run1, run0};
  assign rb   = {1'b0, run1};
  assign md_v[0] = t0_mode;
  assign md_v[1] = t1_mode;

  for (genvar g = 0; g < NT; g++) begin : g_tmr
    tmr_unit #(.SPLIT_M3(g == 0)) u_unit (
      .clk(clk), .rst_n(rst_n), .tick(tick), .mode(md_v[g]),
      .run_a(ra[g]), .run_b(rb[g]), .wr_lo(wl[g]), .wr_hi(wh[g]),
      .wr_data(wr_data), .lo_q(lo_v[g]), .hi_q(hi_v[g]),
      .ovf_a(oa[g]), .ovf_b(ob[g])
    );
  end

  // flag sources; timer 0 split mode takes over timer 1's flag
  assign set_tf0 = oa[0];
  assign set_tf1 = t0_split ? ob[0] : oa[1];

  tmr_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .wr_mode(wr_mode),
    .wr_data(wr_data), .set_f0(set_tf0), .set_f1(set_tf1),
    .ack0(ack0), .ack1(ack1), .ctl_q(ctl_q), .mode_q(mode_q)
  );

  assign lo0  = lo_v[0];
  assign hi0  = hi_v[0];
  assign lo1  = lo_v[1];
  assign hi1  = hi_v[1];
  assign irq0 = ctl_q[5];
  assign irq1 = ctl_q[7];
endmodule

// File: rtl/twin_timer_chk.sv
module twin_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_ctl,
  input logic       ack0,
  input logic [1:0] mode0,
  input logic [1:0] mode1,
  input logic       run0,
  input logic       set_tf0,
  input logic       wr_lo0,
  input logic       wr_hi0,
  input logic       wr_lo1,
  input logic       wr_hi1,
  input logic [7:0] lo0,
  input logic [7:0] hi0,
  input logic [7:0] lo1,
  input logic [7:0] hi1,
  input logic [7:0] ctl_q
);
  assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    set_tf0 |=> ctl_q[5]);

  assert_ack_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack0 && !set_tf0 && !wr_ctl) |=> !ctl_q[5]);

  assert_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode0 == 2'd2 && set_tf0 && !wr_lo0) |=> (lo0 == $past(hi0)));

  assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode0 != 2'd3 && !run0 && !wr_lo0 && !wr_hi0) |=> ($stable(lo0) && $stable(hi0)));

  assert_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode1 == 2'd3 && !wr_lo1 && !wr_hi1) |=> ($stable(lo1) && $stable(hi1)));
endmodule

bind twin_timer twin_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .ack0(ack0),
  .mode0(t0_mode), .mode1(t1_mode), .run0(run0), .set_tf0(set_tf0),
  .wr_lo0(wr_lo0), .wr_hi0(wr_hi0), .wr_lo1(wr_lo1), .wr_hi1(wr_hi1),
  .lo0(lo0), .hi0(hi0), .lo1(lo1), .hi1(hi1), .ctl_q(ctl_q)
);

// File: tb/twin_timer_test.sv
module twin_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  // {mode, hi, lo, ticks, exp_hi, exp_lo, exp_flag}
  localparam logic [42:0] VEC [NV] = '{
    {2'd1, 8'hFF, 8'hFE, 8'd2, 8'h00, 8'h00, 1'b1},
    {2'd1, 8'h12, 8'h34, 8'd5, 8'h12, 8'h39, 1'b0},
    {2'd1, 8'h00, 8'hFF, 8'd1, 8'h01, 8'h00, 1'b0},
    {2'd2, 8'h80, 8'hFE, 8'd3, 8'h80, 8'h81, 1'b1},
    {2'd2, 8'h00, 8'hFF, 8'd1, 8'h00, 8'h00, 1'b1},
    {2'd0, 8'h00, 8'h1F, 8'd1, 8'h01, 8'h00, 1'b0},
    {2'd0, 8'hFF, 8'h1F, 8'd1, 8'h00, 8'h00, 1'b1},
    {2'd0, 8'h05, 8'hE0, 8'd3, 8'h05, 8'hE3, 1'b0},
    {2'd0, 8'hFF, 8'hFF, 8'd1, 8'h00, 8'hE0, 1'b1},
    {2'd3, 8'h33, 8'hFF, 8'd1, 8'h33, 8'h00, 1'b1}
  };

  logic clk = 0, rst_n = 0, tick = 0;
  logic wr_ctl = 0, wr_mode = 0, wr_lo0 = 0, wr_hi0 = 0, wr_lo1 = 0, wr_hi1 = 0;
  logic ack0 = 0, ack1 = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] lo0, hi0, lo1, hi1, ctl_q;
  logic irq0, irq1;
  int checks = 0, errors = 0;

  twin_timer uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // 0 ctl, 1 mode, 2 lo0, 3 hi0, 4 lo1, 5 hi1
  task automatic wreg(input int which, input logic [7:0] d);
    @(negedge clk);
    wr_data = d;
    wr_ctl = (which == 0); wr_mode = (which == 1);
    wr_lo0 = (which == 2); wr_hi0 = (which == 3);
    wr_lo1 = (which == 4); wr_hi1 = (which == 5);
    @(negedge clk);
    {wr_ctl, wr_mode, wr_lo0, wr_hi0, wr_lo1, wr_hi1} = '0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  function automatic string tag_of(input logic [1:0] m);
    case (m)
      2'd0: return "R4";
      2'd1: return "R3";
      2'd2: return "R2";
      default: return "R9";
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired (all R) actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 counts", {lo0, hi0, lo1, hi1}, 32'h0);
    chk("R1 ctl", ctl_q, 8'h00);
    chk("R1 irq", {irq1, irq0}, 2'b00);

    // vector table on timer 0
    for (int i = 0; i < NV; i++) begin
      logic [1:0] m;
      m = VEC[i][42:41];
      wreg(0, 8'h00);
      wreg(1, {6'd0, m});
      wreg(3, VEC[i][40:33]);
      wreg(2, VEC[i][32:25]);
      wreg(0, 8'h10);
      ticks(int'(VEC[i][24:17]));
      chk({tag_of(m), " hi0"}, hi0, VEC[i][16:9]);
      chk({tag_of(m), " lo0"}, lo0, VEC[i][8:1]);
      chk("R5 flag0/irq0", {ctl_q[5], irq0}, {2{VEC[i][0]}});
    end

    // R11 control storage bits and readback
    wreg(0, 8'h0F);
    chk("R11 ctl readback", ctl_q, 8'h0F);
    wreg(0, 8'h00);

    // R7 run bit and tick gating
    wreg(1, 8'h01);
    wreg(2, 8'h10);
    wreg(3, 8'h00);
    ticks(3);
    chk("R7 run off", lo0, 8'h10);
    wreg(0, 8'h10);
    repeat (3) @(negedge clk);
    chk("R7 tick low", lo0, 8'h10);
    ticks(1);
    chk("R7 counts", lo0, 8'h11);

    // R10 write beats count
    @(negedge clk);
    tick = 1; wr_lo0 = 1; wr_data = 8'h55;
    @(negedge clk);
    tick = 0; wr_lo0 = 0;
    chk("R10 write wins", lo0, 8'h55);

    // R5 timer 1 flag and irq1, ack clears (R6)
    wreg(0, 8'h00);
    wreg(1, 8'h04);
    wreg(4, 8'hFF);
    wreg(5, 8'hFF);
    wreg(0, 8'h40);
    ticks(1);
    chk("R5 t1 wrap", {hi1, lo1}, 16'h0000);
    chk("R5 flag1/irq1", {ctl_q[7], irq1}, 2'b11);
    @(negedge clk); ack1 = 1; @(negedge clk); ack1 = 0;
    chk("R6 ack1 clears", irq1, 1'b0);

    // R6 hardware set wins over write and ack
    wreg(0, 8'h00);
    wreg(1, 8'h01);
    wreg(2, 8'hFF);
    wreg(3, 8'hFF);
    wreg(0, 8'h10);
    @(negedge clk); tick = 1; wr_ctl = 1; wr_data = 8'h10;
    @(negedge clk); tick = 0; wr_ctl = 0;
    chk("R6 set beats write", irq0, 1'b1);
    wreg(0, 8'h10);
    chk("R6 write clears", irq0, 1'b0);
    wreg(2, 8'hFF);
    wreg(3, 8'hFF);
    @(negedge clk); tick = 1; ack0 = 1;
    @(negedge clk); tick = 0; ack0 = 0;
    chk("R6 set beats ack", irq0, 1'b1);
    @(negedge clk); ack0 = 1; @(negedge clk); ack0 = 0;
    chk("R6 ack0 clears", irq0, 1'b0);

    // R8 timer 1 halted in mode 3
    wreg(0, 8'h00);
    wreg(1, 8'h0C);
    wreg(4, 8'h12);
    wreg(5, 8'h34);
    wreg(0, 8'h40);
    ticks(4);
    chk("R8 t1 hold", {hi1, lo1}, 16'h3412);
    chk("R8 no flag", irq1, 1'b0);

    // R9 timer 0 split: high byte under run1 owns flag 1
    wreg(0, 8'h00);
    wreg(1, 8'h07);
    wreg(3, 8'hFF);
    wreg(2, 8'h20);
    wreg(4, 8'hFF);
    wreg(5, 8'hFF);
    wreg(0, 8'h40);
    ticks(1);
    chk("R9 hi0 wrap", hi0, 8'h00);
    chk("R9 lo0 idle", lo0, 8'h20);
    chk("R9 irq1 from t0", {irq1, irq0}, 2'b10);
    wreg(0, 8'h40);
    wreg(4, 8'hFF);
    wreg(5, 8'hFF);
    wreg(3, 8'h10);
    ticks(1);
    chk("R9 hi0 count", hi0, 8'h11);
    chk("R9 t1 still counts", {hi1, lo1}, 16'h0000);
    chk("R9 t1 ovf masked", irq1, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule